// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block is the device side of a serial keyboard link. The host sends command bytes to it, and it answers by placing reply bytes in a small circular queue. The host drains that queue one byte at a time through a receive-data read. Key events, already reduced to a 7-bit key number with a release flag, enter the same queue. A data-available flag stays raised for as long as the queue holds anything.

Two command behaviours need state that lasts across bytes. The LED-set command makes the responder swallow the byte that follows it. Lock keys such as caps lock and num lock pass through a per-key filter. Each two-press cycle of a lock key is reduced to a single make and a single break. A new make comes out only on every other physical press.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `rx_avail` is 0 and `rd_data` is 0x00. The LED-skip flag and every lock-key state are cleared.
- R2: Command byte 0x01 queues 0xFF and then 0x04.
- R3: Command byte 0x07 queues 0xFE and then 0x21.
- R4: Command byte 0x0E queues nothing. The next command byte, whatever its value, is consumed without any reply, and decoding then resumes as normal.
- R5: Any command byte other than 0x01, 0x07 and 0x0E queues nothing.
- R6: An accepted key event queues one byte. Bit 7 is the release flag (1 for release) and bits 6:0 are the key number.
- R7: Each lock key keeps a 2-bit state. A press flips bit 0 and a release flips bit 1. A press that leaves the state at 2 is dropped, and a release that leaves it at 3 is dropped. The default lock key numbers are 0x77 and 0x62.
- R8: Within one cycle, a read is served from the queue first. Then the first and second reply bytes of the command are queued, and then the key byte.
- R9: The queue holds `DEPTH` (16) bytes. A byte offered while the queue is full is dropped, and the bytes already stored are kept.
- R10: `rx_avail` is 1 exactly when the queue holds at least one byte, counted after that cycle's read and writes.
- R11: A read of a non-empty queue puts the oldest byte on `rd_data` and removes it. A read of an empty queue leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Host command byte present this cycle |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Key event present this cycle |
| key_num | input | 7 | Key number of the event |
| key_release | input | 1 | 1 for a release event, 0 for a press |
| rd_req | input | 1 | Host reads the receive data register |
| rd_data | output | 8 | Last byte removed from the queue |
| rx_avail | output | 1 | Queue not empty |

## Verification
Each result is registered once. A command, a key event or a read applied before a rising edge changes the queue, `rx_avail` and `rd_data` at that same edge. None of them needs a second cycle to appear. The bench therefore drives inputs on a falling edge and compares both outputs on the next falling edge. It updates its own queue model in the same step, so every comparison falls exactly one edge after the stimulus that caused it. Reset release goes through a two-flop synchronizer, so after deasserting reset the bench waits several cycles before it applies any stimulus.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam logic [7:0] OP_IDENT  = 8'h01;
  localparam logic [7:0] OP_LAYOUT = 8'h07;
  localparam logic [7:0] OP_LEDSET = 8'h0E;

  localparam logic [7:0] ANS_IDENT_HI  = 8'hFF;
  localparam logic [7:0] ANS_IDENT_LO  = 8'h04;
  localparam logic [7:0] ANS_LAYOUT_HI = 8'hFE;
  localparam logic [7:0] ANS_LAYOUT_LO = 8'h21;

  typedef struct packed {
    logic       vld;
    logic [7:0] dat;
  } qbyte_t;
endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output qbyte_t     rep_first,
  output qbyte_t     rep_second,
  output logic       skip_armed
);
  logic skip_q, skip_d;

  always_comb begin
    skip_d     = skip_q;
    rep_first  = '0;
    rep_second = '0;
    if (cmd_valid) begin
      if (skip_q) begin
        skip_d = 1'b0;
      end else begin
        unique case (cmd_byte)
          OP_IDENT: begin
            rep_first  = '{vld: 1'b1, dat: ANS_IDENT_HI};
            rep_second = '{vld: 1'b1, dat: ANS_IDENT_LO};
          end
          OP_LAYOUT: begin
            rep_first  = '{vld: 1'b1, dat: ANS_LAYOUT_HI};
            rep_second = '{vld: 1'b1, dat: ANS_LAYOUT_LO};
          end
          OP_LEDSET: skip_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         skip_q <= 1'b0;
    else if (cmd_valid) skip_q <= skip_d;
  end

  assign skip_armed = skip_q;
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter #(
  parameter int         KW   = 7,
  parameter logic [6:0] CODE = 7'h77
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid,
  input  logic [KW-1:0] key_num,
  input  logic          key_release,
  output logic          drop
);
  logic       hit;
  logic [1:0] st_q, st_d;

  always_comb begin
    hit  = key_valid && (key_num == KW'(CODE));
    st_d = st_q ^ (key_release ? 2'b10 : 2'b01);
    drop = hit && (key_release ? (st_d == 2'b11) : (st_d == 2'b10));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= 2'b00;
    else if (hit) st_q <= st_d;
  end
endmodule

// File: rtl/kbd_reply_ring.sv
module kbd_reply_ring
  import kbd_resp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NWR   = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pop_req,
  input  qbyte_t [NWR-1:0]   wr,
  output logic [7:0]         rd_data,
  output logic               avail,
  output logic [CW-1:0]      level
);
  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    mem_d [DEPTH];
  logic [PW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    data_q, data_d;
  logic          avail_q, avail_d;
  logic          any_wr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mem_d  = mem_q;
    rp_d   = rp_q;
    wp_d   = wp_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    any_wr = 1'b0;
    if (pop_req && (cnt_q != '0)) begin
      data_d = mem_q[rp_q];
      rp_d   = bump(rp_q);
      cnt_d  = cnt_d - 1'b1;
    end
    for (int i = 0; i < NWR; i++) begin
      if (wr[i].vld && (cnt_d < CW'(DEPTH))) begin
        mem_d[wp_d] = wr[i].dat;
        wp_d        = bump(wp_d);
        cnt_d       = cnt_d + 1'b1;
        any_wr      = 1'b1;
      end
    end
    avail_d = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (any_wr) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q    <= '0;
      wp_q    <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      rp_q    <= rp_d;
      wp_q    <= wp_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      avail_q <= avail_d;
    end
  end

  assign rd_data = data_q;
  assign avail   = avail_q;
  assign level   = cnt_q;
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbd_resp_pkg::*;
#(
  parameter int               DEPTH      = 16,
  parameter int               NLOCK      = 2,
  parameter logic [NLOCK*7-1:0] LOCK_CODES = {7'h62, 7'h77},
  localparam int              CW         = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic [6:0] key_num,
  input  logic       key_release,
  input  logic       rd_req,
  output logic [7:0] rd_data,
  output logic       rx_avail
);
  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  qbyte_t           rep_a, rep_b;
  logic             led_skip;
  logic [NLOCK-1:0] lock_drop;
  qbyte_t [2:0]     wr_slots;
  logic [CW-1:0]    q_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  kbd_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .rep_first  (rep_a),
    .rep_second (rep_b),
    .skip_armed (led_skip)
  );

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    kbd_lock_filter #(.KW(7), .CODE(LOCK_CODES[g*7 +: 7])) u_flt (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .key_valid   (key_valid),
      .key_num     (key_num),
      .key_release (key_release),
      .drop        (lock_drop[g])
    );
  end

  always_comb begin
    wr_slots[0] = rep_a;
    wr_slots[1] = rep_b;
    wr_slots[2] = '{vld: key_valid && !(|lock_drop), dat: {key_release, key_num}};
  end

  kbd_reply_ring #(.DEPTH(DEPTH), .NWR(3)) u_ring (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .pop_req (rd_req),
    .wr      (wr_slots),
    .rd_data (rd_data),
    .avail   (rx_avail),
    .level   (q_level)
  );
endmodule

// File: rtl/kbd_responder_chk.sv
module kbd_responder_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          key_valid,
  input logic          rd_req,
  input logic [7:0]    rd_data,
  input logic          rx_avail,
  input logic [CW-1:0] level,
  input logic          skip_armed
);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    level <= CW'(DEPTH));

  assert_avail_level_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_avail == (level != '0));

  assert_empty_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_req && level == '0) |=> $stable(rd_data));

  assert_ident_two_bytes_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_byte == 8'h01 && !skip_armed && !key_valid && !rd_req &&
     level <= CW'(DEPTH - 2)) |=> (level == $past(level) + 2'd2));

  assert_other_silent_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_byte != 8'h01 && cmd_byte != 8'h07 && !key_valid && !rd_req)
    |=> $stable(level));
endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .key_valid  (key_valid),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .rx_avail   (rx_avail),
  .level      (q_level),
  .skip_armed (led_skip)
);

// File: tb/tb_kbd_responder.sv
module tb_kbd_responder;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam logic [6:0] CAPS = 7'h77;
  localparam logic [6:0] NUML = 7'h62;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, key_valid, key_release, rd_req;
  logic [7:0] cmd_byte;
  logic [6:0] key_num;
  logic [7:0] rd_data;
  logic       rx_avail;

  int  vectors = 0, miscompares = 0;
  bit  done = 1'b0;

  logic [7:0] mq [DEPTH];
  int         mh, mc;
  bit         mskip;
  logic [1:0] mlock [2];
  logic [7:0] exp_rd;

  kbd_responder dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_num(key_num), .key_release(key_release),
    .rd_req(rd_req), .rd_data(rd_data), .rx_avail(rx_avail)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic push(input logic [7:0] b);
    if (mc < DEPTH) begin
      mq[(mh + mc) % DEPTH] = b;
      mc++;
    end
  endtask

  function automatic bit lock_pass(input int idx, input bit rel);
    logic [1:0] nx;
    nx = mlock[idx] ^ (rel ? 2'b10 : 2'b01);
    mlock[idx] = nx;
    return rel ? (nx != 2'b11) : (nx != 2'b10);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    mh = 0; mc = 0; mskip = 0; mlock[0] = 0; mlock[1] = 0; exp_rd = 8'h00;
  endtask

  task automatic step(input bit cv, input logic [7:0] cb, input bit kv,
                      input logic [6:0] kn, input bit kr, input bit rd, input string tag);
    bit pass;
    cmd_valid = cv; cmd_byte = cb; key_valid = kv; key_num = kn;
    key_release = kr; rd_req = rd;
    @(negedge clk);
    if (rd && mc > 0) begin
      exp_rd = mq[mh]; mh = (mh + 1) % DEPTH; mc--;
    end
    if (cv) begin
      if (mskip) mskip = 0;
      else if (cb == 8'h01) begin push(8'hFF); push(8'h04); end
      else if (cb == 8'h07) begin push(8'hFE); push(8'h21); end
      else if (cb == 8'h0E) mskip = 1;
    end
    if (kv) begin
      pass = 1;
      if (kn == CAPS) pass = lock_pass(0, kr);
      else if (kn == NUML) pass = lock_pass(1, kr);
      if (pass) push({kr, kn});
    end
    chk({tag, " rd_data"}, rd_data, exp_rd);
    chk({tag, " rx_avail R10"}, {7'd0, rx_avail}, {7'd0, mc != 0});
  endtask

  task automatic idle_read(input string tag);
    step(0, 8'h00, 0, 7'h00, 0, 1, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 0; cmd_byte = 0; key_valid = 0; key_num = 0;
    key_release = 0; rd_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    do_reset();
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset rx_avail", {7'd0, rx_avail}, 8'h00);

    step(1, 8'h01, 0, 0, 0, 0, "R2");
    idle_read("R2"); chk("R2 first", rd_data, 8'hFF);
    idle_read("R2"); chk("R2 second", rd_data, 8'h04);

    step(1, 8'h07, 0, 0, 0, 0, "R3");
    idle_read("R3"); chk("R3 first", rd_data, 8'hFE);
    idle_read("R3"); chk("R3 second", rd_data, 8'h21);

    step(1, 8'h0E, 0, 0, 0, 0, "R4");
    step(1, 8'h01, 0, 0, 0, 0, "R4");
    chk("R4 skipped byte no reply", {7'd0, rx_avail}, 8'h00);
    step(1, 8'h07, 0, 0, 0, 0, "R4");
    idle_read("R4"); chk("R4 decode resumes", rd_data, 8'hFE);
    idle_read("R4");

    step(1, 8'h55, 0, 0, 0, 0, "R5");
    chk("R5 no reply", {7'd0, rx_avail}, 8'h00);

    step(0, 0, 1, 7'h10, 0, 0, "R6");
    step(0, 0, 1, 7'h10, 1, 0, "R6");
    idle_read("R6"); chk("R6 press byte", rd_data, 8'h10);
    idle_read("R6"); chk("R6 release byte", rd_data, 8'h90);

    step(0, 0, 1, CAPS, 0, 0, "R7");
    step(0, 0, 1, CAPS, 1, 0, "R7");
    step(0, 0, 1, CAPS, 0, 0, "R7");
    step(0, 0, 1, CAPS, 1, 0, "R7");
    idle_read("R7"); chk("R7 make kept", rd_data, 8'h77);
    idle_read("R7"); chk("R7 break kept", rd_data, 8'hF7);
    chk("R7 two dropped", {7'd0, rx_avail}, 8'h00);

    step(1, 8'h07, 1, 7'h05, 0, 1, "R8");
    idle_read("R8"); chk("R8 order 1", rd_data, 8'hFE);
    idle_read("R8"); chk("R8 order 2", rd_data, 8'h21);
    idle_read("R8"); chk("R8 order 3", rd_data, 8'h05);

    for (int i = 0; i < 9; i++) step(1, 8'h01, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 7'h33, 0, 0, "R9");
    for (int i = 0; i < DEPTH; i++) idle_read("R9");
    chk("R9 last kept", rd_data, 8'h04);
    chk("R9 drained", {7'd0, rx_avail}, 8'h00);

    idle_read("R11");
    chk("R11 empty read holds", rd_data, 8'h04);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] cb;
      logic [6:0] kn;
      int sel;
      sel = $urandom_range(0, 3);
      cb = (sel == 0) ? 8'h01 : (sel == 1) ? 8'h07 : (sel == 2) ? 8'h0E : 8'($urandom);
      sel = $urandom_range(0, 3);
      kn = (sel == 0) ? CAPS : (sel == 1) ? NUML : 7'($urandom);
      step($urandom_range(0, 3) == 0, cb, $urandom_range(0, 2) == 0, kn,
           1'($urandom), $urandom_range(0, 1) == 1, "R11 random");
    end

    do_reset();
    chk("R1 rereset rx_avail", {7'd0, rx_avail}, 8'h00);
    chk("R1 rereset rd_data", rd_data, 8'h00);
    step(0, 0, 1, NUML, 0, 0, "R1");
    idle_read("R1"); chk("R1 lock state cleared", rd_data, 8'h62);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule